// File: doc/BRIEF.md
# Two-Stage Virtual-Channel Flit Pipeline

This block is the buffering core of a network-on-chip router port set. It has `NPORT` input ports and `NPORT` output ports. Every input port owns one receive queue and one staging queue for each of `NVC` virtual channels.

A flit that arrives with its valid bit set is written into the receive queue picked by its port and its channel field. One clock later it moves on into the matching staging queue. The heads of the staging queues then compete for the output port named in each flit's destination field. A rotating priority decides each contest: the scan runs over ports first and then over the channels inside each port.

Every transfer between queues is registered. The two storage stages therefore add exactly one cycle each, and a flit never skips a stage within a single clock. A flit that cannot be stored is flagged on a per-port drop line in the cycle it arrives, so it is never lost silently.

Top module: `vc_flit_pipe2`

## Requirements
- R1: The channel field of an input port (`in_vc[p*VCW +: VCW]`) selects the queue pair that stores the flit. A flit leaves with that same channel number on `out_vc[o*VCW +: VCW]`.
- R2: Each receive queue and each staging queue holds at most `QDEPTH` flits. A write into a receive queue happens only when that queue is not full at the clock edge.
- R3: `in_drop[p]` is high, in the same cycle, for a valid flit that is rejected, and the rejected flit is discarded. A flit is rejected when its target receive queue is full, when its destination field (`in_dest[p*PW +: PW]`) is `NPORT` or more, or when its channel field is `NVC` or more.
- R4: A head moves from a receive queue to its staging queue only when the receive queue is non-empty and the staging queue is not full, both judged on the state before the edge. Each channel of each port keeps its flits in order.
- R5: Each output port is given the staging head that comes first in the scan order. The scan takes ports in the order start_port, start_port+1, and so on, modulo `NPORT`. Inside port i it takes channels in the order start_vc[i], start_vc[i]+1, and so on, modulo `NVC`.
- R6: A flit presented before clock edge k is stored at edge k, moves to staging at edge k+1, and is visible on the outputs between edges k+1 and k+2. Every stage reads only state from before the edge.
- R7: At most one flit leaves per output port per cycle. A shown flit is removed at the next edge, and a flit that loses arbitration stays at the head of its queue.
- R8: After any grant, start_port becomes one past the port of the earliest grant in scan order. For every port that was granted, start_vc becomes one past its earliest granted channel.
- R9: `rst` is synchronous and active high. While it is high there are no writes, no moves, no outputs and no drops. It empties every queue and sets all rotating pointers to zero.
- R10: `out_src[o*PW +: PW]` gives the input port of the flit on output o, and `out_data[o*DATA_W +: DATA_W]` gives its payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | NPORT | Flit present on each input port |
| in_vc | input | NPORT*VCW | Channel field per input port |
| in_dest | input | NPORT*PW | Destination output port per input |
| in_data | input | NPORT*DATA_W | Payload per input port |
| in_drop | output | NPORT | Flit rejected this cycle, per input port |
| out_valid | output | NPORT | Flit leaving on each output port |
| out_vc | output | NPORT*VCW | Channel of the leaving flit |
| out_src | output | NPORT*PW | Input port of the leaving flit |
| out_data | output | NPORT*DATA_W | Payload of the leaving flit |

## Verification
A wrong fill level in a receive queue first shows up on `in_drop`, either too early or too late, in the very cycle of the next arrival to that channel. A wrong staging head or a lost move shows up two edges after the input as a wrong or missing `out_data`. A stale rotating pointer shows up as the wrong `out_src` on the first contested output after the faulty grant. The bench compares every output against its own queue model on every clock, so any such divergence is caught within one cycle of becoming visible.

// File: rtl/vcp_pkg.sv
package vcp_pkg;

  // Next position on a ring of the given size.
  function automatic int wrap_next(input int cur, input int ring);
    return (cur + 1 >= ring) ? 0 : cur + 1;
  endfunction

  // Position reached after stepping off places from base on a ring.
  function automatic int wrap_add(input int base, input int off, input int ring);
    return (base + off) % ring;
  endfunction

  // Flat slot number of a (port, channel) pair.
  function automatic int slot_of(input int port, input int vc, input int nvc);
    return port * nvc + vc;
  endfunction

endpackage

// File: rtl/vcp_fifo.sv
module vcp_fifo #(
  parameter int WIDTH = 19,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wr_ptr;
  logic [AW:0] rd_ptr;
  logic [AW:0] fill;

  assign fill  = wr_ptr - rd_ptr;
  assign full  = (fill == (AW+1)'(DEPTH));
  assign empty = (wr_ptr == rd_ptr);
  assign dout  = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R2
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R4
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst) fill <= (AW+1)'(DEPTH)); // R2

endmodule

// File: rtl/vcp_rr_select.sv
module vcp_rr_select
  import vcp_pkg::*;
#(
  parameter int NPORT = 6,
  parameter int NVC   = 2,
  localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int VCW   = (NVC > 1) ? $clog2(NVC) : 1,
  localparam int SLOTS = NPORT * NVC
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SLOTS-1:0]    head_valid,
  input  logic [SLOTS*PW-1:0] head_dest,
  output logic [SLOTS-1:0]    grant,
  output logic [NPORT-1:0]    sel_valid,
  output logic [NPORT*PW-1:0] sel_port,
  output logic [NPORT*VCW-1:0] sel_vc
);

  logic [PW-1:0]  start_port;
  logic [VCW-1:0] start_vc [NPORT];

  // Named events for the pointer update and the checks.
  logic           any_grant;
  logic [PW-1:0]  first_port;
  logic [NPORT-1:0] port_hit;
  logic [VCW-1:0] vc_first [NPORT];

  always_comb begin
    int pi;
    int vi;
    int q;
    int o;
    grant      = '0;
    sel_valid  = '0;
    sel_port   = '0;
    sel_vc     = '0;
    any_grant  = 1'b0;
    first_port = '0;
    port_hit   = '0;
    for (int n = 0; n < NPORT; n++) vc_first[n] = '0;
    for (int j = 0; j < NPORT; j++) begin
      pi = wrap_add(int'(start_port), j, NPORT);
      for (int k = 0; k < NVC; k++) begin
        vi = wrap_add(int'(start_vc[pi]), k, NVC);
        q  = slot_of(pi, vi, NVC);
        o  = int'(head_dest[q*PW +: PW]);
        if (head_valid[q] && o < NPORT) begin
          if (!sel_valid[o]) begin
            sel_valid[o]           = 1'b1;
            sel_port[o*PW +: PW]   = PW'(pi);
            sel_vc[o*VCW +: VCW]   = VCW'(vi);
            grant[q]               = 1'b1;
            if (!any_grant) begin
              any_grant  = 1'b1;
              first_port = PW'(pi);
            end
            if (!port_hit[pi]) begin
              port_hit[pi] = 1'b1;
              vc_first[pi] = VCW'(vi);
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_port <= '0;
      for (int n = 0; n < NPORT; n++) start_vc[n] <= '0;
    end else begin
      if (any_grant) start_port <= PW'(wrap_next(int'(first_port), NPORT));
      for (int n = 0; n < NPORT; n++) begin
        if (port_hit[n]) start_vc[n] <= VCW'(wrap_next(int'(vc_first[n]), NVC));
      end
    end
  end

  AST_GRANT_HAS_HEAD: assert property (@(posedge clk) disable iff (rst) (grant & ~head_valid) == '0); // R7

  generate
    for (genvar o = 0; o < NPORT; o++) begin : g_out_chk
      logic [SLOTS-1:0] dest_hit;
      always_comb begin
        for (int q = 0; q < SLOTS; q++)
          dest_hit[q] = head_valid[q] && (head_dest[q*PW +: PW] == PW'(o));
      end
      AST_ONE_GRANT_PER_OUT: assert property (@(posedge clk) disable iff (rst)
        $countones(grant & dest_hit) <= 1); // R7
      AST_WAITING_HEAD_SERVED: assert property (@(posedge clk) disable iff (rst)
        (dest_hit != '0) |-> sel_valid[o]); // R5
    end
  endgenerate

endmodule

// File: rtl/vc_flit_pipe2.sv
module vc_flit_pipe2
  import vcp_pkg::*;
#(
  parameter int NPORT  = 6,
  parameter int NVC    = 2,
  parameter int QDEPTH = 4,
  parameter int DATA_W = 16,
  localparam int PW  = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int VCW = (NVC > 1) ? $clog2(NVC) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPORT-1:0]        in_valid,
  input  logic [NPORT*VCW-1:0]    in_vc,
  input  logic [NPORT*PW-1:0]     in_dest,
  input  logic [NPORT*DATA_W-1:0] in_data,
  output logic [NPORT-1:0]        in_drop,
  output logic [NPORT-1:0]        out_valid,
  output logic [NPORT*VCW-1:0]    out_vc,
  output logic [NPORT*PW-1:0]     out_src,
  output logic [NPORT*DATA_W-1:0] out_data
);

  localparam int SLOTS = NPORT * NVC;
  localparam int FW    = PW + DATA_W;

  // Stage events, brought out by name.
  logic [SLOTS-1:0] q1_push, q1_full, q1_empty;
  logic [SLOTS-1:0] mv, q2_full, q2_empty, q2_pop;
  logic [FW-1:0]    q1_dout [SLOTS];
  logic [FW-1:0]    q2_dout [SLOTS];
  logic [FW-1:0]    in_flit [NPORT];
  logic [NPORT-1:0] port_ok;
  logic [SLOTS-1:0]    head_valid;
  logic [SLOTS*PW-1:0] head_dest;
  logic [NPORT*PW-1:0]  sel_port;
  logic [NPORT*VCW-1:0] sel_vc;
  logic [NPORT-1:0]     sel_valid;

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      port_ok[p] = (int'(in_dest[p*PW +: PW]) < NPORT) && (int'(in_vc[p*VCW +: VCW]) < NVC);
      in_flit[p] = {in_dest[p*PW +: PW], in_data[p*DATA_W +: DATA_W]};
    end
  end

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      for (genvar v = 0; v < NVC; v++) begin : g_vc
        localparam int Q = p * NVC + v;

        // Stage one: receive queue write.
        assign q1_push[Q] = !rst && in_valid[p] && port_ok[p] &&
                            (in_vc[p*VCW +: VCW] == VCW'(v)) && !q1_full[Q];
        // Stage two: registered move into the staging queue.
        assign mv[Q] = !rst && !q1_empty[Q] && !q2_full[Q];

        vcp_fifo #(.WIDTH(FW), .DEPTH(QDEPTH)) u_rxq (
          .clk(clk), .rst(rst), .push(q1_push[Q]), .pop(mv[Q]),
          .din(in_flit[p]), .dout(q1_dout[Q]), .full(q1_full[Q]), .empty(q1_empty[Q])
        );

        vcp_fifo #(.WIDTH(FW), .DEPTH(QDEPTH)) u_stq (
          .clk(clk), .rst(rst), .push(mv[Q]), .pop(q2_pop[Q]),
          .din(q1_dout[Q]), .dout(q2_dout[Q]), .full(q2_full[Q]), .empty(q2_empty[Q])
        );

        assign head_valid[Q]           = !rst && !q2_empty[Q];
        assign head_dest[Q*PW +: PW]   = q2_dout[Q][FW-1 -: PW];
      end

      AST_DROP_NO_STORE: assert property (@(posedge clk) disable iff (rst)
        in_drop[p] |-> (q1_push[p*NVC +: NVC] == '0)); // R3
    end
  endgenerate

  always_comb begin
    logic target_full;
    for (int p = 0; p < NPORT; p++) begin
      target_full = 1'b0;
      for (int v = 0; v < NVC; v++) begin
        if (in_vc[p*VCW +: VCW] == VCW'(v)) target_full = q1_full[slot_of(p, v, NVC)];
      end
      in_drop[p] = !rst && in_valid[p] && (!port_ok[p] || target_full);
    end
  end

  vcp_rr_select #(.NPORT(NPORT), .NVC(NVC)) u_sel (
    .clk(clk), .rst(rst), .head_valid(head_valid), .head_dest(head_dest),
    .grant(q2_pop), .sel_valid(sel_valid), .sel_port(sel_port), .sel_vc(sel_vc)
  );

  always_comb begin
    int q;
    out_valid = sel_valid;
    out_vc    = sel_vc;
    out_src   = sel_port;
    out_data  = '0;
    for (int o = 0; o < NPORT; o++) begin
      q = slot_of(int'(sel_port[o*PW +: PW]), int'(sel_vc[o*VCW +: VCW]), NVC);
      if (sel_valid[o] && q < SLOTS) out_data[o*DATA_W +: DATA_W] = q2_dout[q][DATA_W-1:0];
    end
  end

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_valid == '0)); // R9
  AST_NO_MOVE_INTO_FULL: assert property (@(posedge clk) disable iff (rst)
    (mv & q2_full) == '0); // R4

endmodule

// File: tb/tb_vc_flit_pipe2.sv
`timescale 1ns/1ps
module tb_vc_flit_pipe2;
  localparam int P = 6;
  localparam int V = 2;
  localparam int D = 4;
  localparam int DW = 16;
  localparam int PW = 3;
  localparam int VCW = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [P-1:0]     in_valid;
  logic [P*VCW-1:0] in_vc;
  logic [P*PW-1:0]  in_dest;
  logic [P*DW-1:0]  in_data;
  logic [P-1:0]     in_drop;
  logic [P-1:0]     out_valid;
  logic [P*VCW-1:0] out_vc;
  logic [P*PW-1:0]  out_src;
  logic [P*DW-1:0]  out_data;

  always #2 clk = ~clk;

  vc_flit_pipe2 #(.NPORT(P), .NVC(V), .QDEPTH(D), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vc(in_vc), .in_dest(in_dest),
    .in_data(in_data), .in_drop(in_drop), .out_valid(out_valid), .out_vc(out_vc),
    .out_src(out_src), .out_data(out_data)
  );

  // Stimulus as plain integers.
  int iv[P], ivc[P], idest[P], idat[P];
  // Reference model: one queue per port and channel in each stage.
  int mq1[P][V][$];
  int mq2[P][V][$];
  int msp;
  int msvc[P];
  int ev[P], ed[P], evc[P], esrc[P], edrop[P];
  int gq[P][V];
  int nchk = 0, nfail = 0;
  bit seen_drop = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive();
    for (int p = 0; p < P; p++) begin
      in_valid[p]            = iv[p][0];
      in_vc[p*VCW +: VCW]    = ivc[p][VCW-1:0];
      in_dest[p*PW +: PW]    = idest[p][PW-1:0];
      in_data[p*DW +: DW]    = idat[p][DW-1:0];
    end
  endtask

  task automatic idle();
    for (int p = 0; p < P; p++) begin iv[p] = 0; ivc[p] = 0; idest[p] = 0; idat[p] = 0; end
    drive();
  endtask

  task automatic model_eval();
    int pi, vi, f, o;
    for (int p = 0; p < P; p++) begin
      ev[p] = 0; ed[p] = 0; evc[p] = 0; esrc[p] = 0; edrop[p] = 0;
      for (int v = 0; v < V; v++) gq[p][v] = 0;
    end
    if (!rst) begin
      for (int j = 0; j < P; j++) begin
        pi = (msp + j) % P;
        for (int k = 0; k < V; k++) begin
          vi = (msvc[pi] + k) % V;
          if (mq2[pi][vi].size() > 0) begin
            f = mq2[pi][vi][0];
            o = f >> 16;
            if (ev[o] == 0) begin
              ev[o] = 1; ed[o] = f & 'hFFFF; evc[o] = vi; esrc[o] = pi; gq[pi][vi] = 1;
            end
          end
        end
      end
      for (int p = 0; p < P; p++)
        if (iv[p] != 0)
          edrop[p] = (idest[p] >= P || ivc[p] >= V || mq1[p][ivc[p]].size() >= D) ? 1 : 0;
    end
  endtask

  task automatic model_edge();
    int mvf[P][V];
    int pi, vi, nsp, found;
    int pfound[P];
    int nvc[P];
    if (rst) begin
      for (int p = 0; p < P; p++) begin
        msvc[p] = 0;
        for (int v = 0; v < V; v++) begin mq1[p][v].delete(); mq2[p][v].delete(); end
      end
      msp = 0;
      return;
    end
    found = 0; nsp = msp;
    for (int p = 0; p < P; p++) begin pfound[p] = 0; nvc[p] = msvc[p]; end
    for (int j = 0; j < P; j++) begin
      pi = (msp + j) % P;
      for (int k = 0; k < V; k++) begin
        vi = (msvc[pi] + k) % V;
        if (gq[pi][vi] != 0) begin
          if (found == 0) begin found = 1; nsp = (pi + 1) % P; end
          if (pfound[pi] == 0) begin pfound[pi] = 1; nvc[pi] = (vi + 1) % V; end
        end
      end
    end
    for (int p = 0; p < P; p++)
      for (int v = 0; v < V; v++)
        mvf[p][v] = (mq1[p][v].size() > 0 && mq2[p][v].size() < D) ? 1 : 0;
    for (int p = 0; p < P; p++)
      for (int v = 0; v < V; v++) begin
        if (gq[p][v] != 0) void'(mq2[p][v].pop_front());
        if (mvf[p][v] != 0) mq2[p][v].push_back(mq1[p][v].pop_front());
      end
    for (int p = 0; p < P; p++)
      if (iv[p] != 0 && edrop[p] == 0)
        mq1[p][ivc[p]].push_back((idest[p] << 16) | (idat[p] & 'hFFFF));
    msp = nsp;
    for (int p = 0; p < P; p++) msvc[p] = nvc[p];
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic finish_cyc();
    logic [P-1:0] exp_v, exp_d;
    model_eval();
    for (int p = 0; p < P; p++) begin exp_v[p] = ev[p][0]; exp_d[p] = edrop[p][0]; end
    chk(out_valid == exp_v, "R7", "out_valid", int'(out_valid), int'(exp_v));
    chk(in_drop == exp_d, "R3", "in_drop", int'(in_drop), int'(exp_d));
    if (in_drop != 0) seen_drop = 1;
    for (int o = 0; o < P; o++) begin
      if (ev[o] != 0 && out_valid[o]) begin
        chk(int'(out_data[o*DW +: DW]) == ed[o], "R4", "out_data", int'(out_data[o*DW +: DW]), ed[o]);
        chk(int'(out_vc[o*VCW +: VCW]) == evc[o], "R1", "out_vc", int'(out_vc[o*VCW +: VCW]), evc[o]);
        chk(int'(out_src[o*PW +: PW]) == esrc[o], "R5 R8", "out_src", int'(out_src[o*PW +: PW]), esrc[o]);
      end
    end
    model_edge();
    @(negedge clk);
  endtask

  task automatic cyc();
    settle();
    finish_cyc();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    #800000;
    nfail++;
    nchk++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    idle();
    msp = 0;
    for (int p = 0; p < P; p++) msvc[p] = 0;
    @(negedge clk);

    // R9: flits offered during reset are neither stored nor dropped.
    for (int n = 0; n < 3; n++) begin
      for (int p = 0; p < P; p++) begin iv[p] = 1; idest[p] = p; ivc[p] = 0; idat[p] = 100 + p; end
      drive();
      settle();
      chk(in_drop == '0, "R9", "drop in reset", int'(in_drop), 0);
      chk(out_valid == '0, "R9", "out in reset", int'(out_valid), 0);
      finish_cyc();
    end
    rst = 1'b0;
    idle();
    for (int n = 0; n < 2; n++) begin
      settle();
      chk(out_valid == '0, "R9", "empty after reset", int'(out_valid), 0);
      finish_cyc();
    end

    // R6: two edges from input to output.
    iv[0] = 1; ivc[0] = 1; idest[0] = 3; idat[0] = 'h0ABC; drive();
    settle();
    chk(out_valid == '0, "R6", "out at entry", int'(out_valid), 0);
    finish_cyc();
    idle();
    settle();
    chk(out_valid == '0, "R6", "out after one edge", int'(out_valid), 0);
    finish_cyc();
    settle();
    chk(out_valid == 6'b001000, "R6", "out after two edges", int'(out_valid), 'h08);
    chk(out_data[3*DW +: DW] == 16'h0ABC, "R10", "payload", int'(out_data[3*DW +: DW]), 'hABC);
    chk(out_vc[3] == 1'b1, "R1", "channel carried", int'(out_vc[3]), 1);
    chk(out_src[3*PW +: PW] == 3'd0, "R10", "source port", int'(out_src[3*PW +: PW]), 0);
    finish_cyc();
    settle();
    chk(out_valid == '0, "R7", "removed after grant", int'(out_valid), 0);
    finish_cyc();

    // R5: start_port is now 1, so port 1 beats port 0 for output 2.
    iv[0] = 1; ivc[0] = 0; idest[0] = 2; idat[0] = 'h11;
    iv[1] = 1; ivc[1] = 0; idest[1] = 2; idat[1] = 'h22; drive();
    cyc();
    idle();
    cyc();
    settle();
    chk(out_src[2*PW +: PW] == 3'd1, "R5", "rotating winner", int'(out_src[2*PW +: PW]), 1);
    chk(out_data[2*DW +: DW] == 16'h22, "R5", "winner data", int'(out_data[2*DW +: DW]), 'h22);
    finish_cyc();
    settle();
    chk(out_src[2*PW +: PW] == 3'd0, "R7", "loser kept", int'(out_src[2*PW +: PW]), 0);
    chk(out_data[2*DW +: DW] == 16'h11, "R7", "loser data", int'(out_data[2*DW +: DW]), 'h11);
    finish_cyc();

    // R2: all ports flood output 0 until queues fill and drops appear.
    seen_drop = 0;
    for (int n = 0; n < 24; n++) begin
      for (int p = 0; p < P; p++) begin iv[p] = 1; ivc[p] = 0; idest[p] = 0; idat[p] = n * 8 + p; end
      drive();
      cyc();
    end
    chk(seen_drop, "R2", "full queue rejects", int'(seen_drop), 1);
    idle();
    for (int n = 0; n < 60; n++) cyc();

    // R3: destination beyond the port count is rejected.
    iv[2] = 1; ivc[2] = 0; idest[2] = 7; idat[2] = 'h77; drive();
    settle();
    chk(in_drop == 6'b000100, "R3", "bad destination", int'(in_drop), 'h04);
    finish_cyc();
    idle();
    for (int n = 0; n < 3; n++) begin
      settle();
      chk(out_valid == '0, "R3", "bad flit discarded", int'(out_valid), 0);
      finish_cyc();
    end

    // Random traffic with a reset in the middle.
    for (int n = 0; n < 3000; n++) begin
      rst = (n >= 1500 && n < 1502);
      for (int p = 0; p < P; p++) begin
        iv[p] = $urandom_range(0, 1);
        ivc[p] = $urandom_range(0, V - 1);
        idest[p] = ($urandom_range(0, 19) == 0) ? 6 + $urandom_range(0, 1) : $urandom_range(0, P - 1);
        idat[p] = $urandom_range(0, 'hFFFF);
      end
      drive();
      cyc();
    end
    rst = 1'b0;
    idle();
    for (int n = 0; n < 40; n++) cyc();

    summary();
    $finish;
  end

endmodule